// File: doc/BRIEF.md
# Bit-Serial Adder

This block sums two unsigned operands of a parameterised width with a single full adder and one carry flip-flop, handling one bit position per clock. The augend and the addend each sit in their own right-shifting register. On every enabled cycle the two low-order bits and the stored carry go into the full adder. The sum bit enters the top of the augend register, and the new carry is saved for the next bit. After the last position the augend register holds the complete sum, and the carry flip-flop holds the carry-out.

A one-cycle start pulse loads both operands in parallel, zeroes the carry and arms an internal bit counter. The counter keeps the block busy until exactly one shift per bit position has happened. While the block is busy, the shift-enable input can stall the operation on any cycle without losing state. As the addend shifts out, the addend register takes a new word bit by bit from a serial line, so the next operand can be assembled during the current addition. A one-cycle done pulse marks completion.

Top module: `bit_serial_adder`

## Requirements
- R1: While `clear` is high, at the next clock edge `sum`, `addend` and `carryOut` become 0 and `busy` and `done` become low.
- R2: A `start` pulse taken while idle loads `opA` into the augend register and `opB` into the addend register at that edge, and sets `busy`. After that edge `sum` equals `opA`.
- R3: A `start` pulse taken while idle clears the carry, so `carryOut` reads 0 after the load even if the previous addition ended with a carry.
- R4: After exactly W cycles with `shiftEn` high, processed least significant bit first, `sum` equals (opA + opB) mod 2^W and `carryOut` equals bit W of opA + opB.
- R5: While busy, a cycle with `shiftEn` low leaves `sum`, `addend`, `carryOut` and the bit count unchanged. The operation simply takes longer.
- R6: `done` is high for exactly one cycle, following the clock edge that performs the W-th enabled shift, and `busy` falls at that same edge.
- R7: Each enabled shift moves `serIn` into the top bit of the addend register. After completion, bit i of `addend` equals the `serIn` value present on the i-th enabled shift, counting from 0.
- R8: A `start` pulse while `busy` is high is ignored, so the operation in progress completes with its original operands.
- R9: Once idle, `sum` and `carryOut` hold the result until the next `start` or `clear`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clear | input | 1 | Synchronous active-high clear of all state |
| start | input | 1 | Load both operands, clear the carry and begin an addition |
| shiftEn | input | 1 | Permits one bit step on this cycle while busy |
| serIn | input | 1 | Serial bit shifted into the top of the addend register |
| opA | input | W | Augend, loaded in parallel on start |
| opB | input | W | Addend, loaded in parallel on start |
| busy | output | 1 | An addition is in progress |
| done | output | 1 | One-cycle pulse after the final bit step |
| sum | output | W | Augend register contents; the sum once done |
| addend | output | W | Addend register contents |
| carryOut | output | 1 | Carry flip-flop; the final carry once done |

## Verification
The load is visible one edge after `start`, so the bench checks the loaded augend and the cleared carry at the falling edge that follows the start cycle. The result, the carry and the serially assembled addend are due at the edge that performs the W-th enabled shift, however many stalled cycles came before it. A driver therefore queues the expected values, and a monitor compares them only when it sees `done` at a falling edge. Stalled cycles are checked one falling edge after they are driven, against the value recorded before the stall. The hold of the result is checked several idle cycles after `done`.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // Strobes issued by the sequencer to the datapath each cycle.
  typedef struct packed {
    logic load;   // parallel load of both operands, carry cleared
    logic shift;  // one bit step through the full adder
  } strobe_t;
endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);
  always_comb begin
    s    = a ^ b ^ cin;
    cout = (a & b) | (a & cin) | (b & cin);
  end
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic    clk,
  input  logic    clear,
  input  logic    start,
  input  logic    shiftEn,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitCnt;

  always_comb begin
    strb.load  = start & ~busy;
    strb.shift = busy & shiftEn;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (strb.shift) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: completion pulse lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (clear)
    done |=> !done);

  // R6: busy only drops together with the completion pulse
  a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (clear)
    $fell(busy) |-> done);

  // R5: a stalled cycle leaves the bit count alone
  a_r5_count_hold: assert property (@(posedge clk) disable iff (clear)
    (busy && !shiftEn && !start) |=> $stable(bitCnt) && busy);

  // R8: a start while busy does not restart the count
  a_r8_start_busy: assert property (@(posedge clk) disable iff (clear)
    (busy && start && !shiftEn) |=> busy && $stable(bitCnt));
endmodule

// File: rtl/bsa_dpath.sv
module bsa_dpath
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clear,
  input  strobe_t      strb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         serIn,
  output logic [W-1:0] regA,
  output logic [W-1:0] regB,
  output logic         carry
);
  logic sumBit;
  logic carryNext;

  bsa_full_adder u_fa (
    .a    (regA[0]),
    .b    (regB[0]),
    .cin  (carry),
    .s    (sumBit),
    .cout (carryNext)
  );

  always_ff @(posedge clk) begin
    if (clear) begin
      regA  <= '0;
      regB  <= '0;
      carry <= 1'b0;
    end else if (strb.load) begin
      regA  <= opA;
      regB  <= opB;
      carry <= 1'b0;
    end else if (strb.shift) begin
      regA  <= {sumBit, regA[W-1:1]};
      regB  <= {serIn, regB[W-1:1]};
      carry <= carryNext;
    end
  end

  // R2: parallel load captures the augend
  a_r2_load_aug: assert property (@(posedge clk) disable iff (clear)
    strb.load |=> regA == $past(opA));

  // R3: carry starts every addition at zero
  a_r3_carry_zero: assert property (@(posedge clk) disable iff (clear)
    strb.load |=> carry == 1'b0);

  // R5: no strobe, no change in any register
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (clear)
    (!strb.load && !strb.shift) |=> $stable(regA) && $stable(regB) && $stable(carry));

  // R7: serial line enters the top of the addend register
  a_r7_serial_top: assert property (@(posedge clk) disable iff (clear)
    (strb.shift && !strb.load) |=> regB[W-1] == $past(serIn));
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         start,
  input  logic         shiftEn,
  input  logic         serIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum,
  output logic [W-1:0] addend,
  output logic         carryOut
);
  strobe_t strb;

  bsa_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .clear   (clear),
    .start   (start),
    .shiftEn (shiftEn),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  bsa_dpath #(.W(W)) u_dpath (
    .clk   (clk),
    .clear (clear),
    .strb  (strb),
    .opA   (opA),
    .opB   (opB),
    .serIn (serIn),
    .regA  (sum),
    .regB  (addend),
    .carry (carryOut)
  );
endmodule

// File: tb/sim_bit_serial_adder.sv
module sim_bit_serial_adder;
  localparam int W = 8;
  localparam time PERIOD = 10ns;

  typedef struct {
    logic [W-1:0] sum;
    logic [W-1:0] addend;
    logic         cy;
  } exp_t;

  logic clk = 1'b0;
  logic clear, start, shiftEn, serIn;
  logic [W-1:0] opA, opB;
  logic busy, done, carryOut;
  logic [W-1:0] sum, addend;

  int nChecks = 0;
  int nErrors = 0;
  exp_t sb[$];
  logic prevDone = 1'b0;
  logic [W-1:0] lastSum;
  logic lastCy;

  always #(PERIOD/2) clk = ~clk;

  bit_serial_adder #(.W(W)) u0 (
    .clk(clk), .clear(clear), .start(start), .shiftEn(shiftEn), .serIn(serIn),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .sum(sum),
    .addend(addend), .carryOut(carryOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: results are due when done is seen.
  always @(negedge clk) begin
    if (!clear) begin
      if (done) begin
        check(!prevDone, "R6 done width", 1, 0);
        check(busy == 1'b0, "R6 busy falls with done", busy, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R4 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(sum == e.sum, "R4 sum", sum, e.sum);
          check(carryOut == e.cy, "R4 carryOut", carryOut, e.cy);
          check(addend == e.addend, "R7 serial addend", addend, e.addend);
        end
      end
      prevDone = done;
    end
  end

  // Driver: one addition, optional stalls and an ignored start.
  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] ser, input bit stall, input bit inject);
    logic [W:0] full;
    logic [W-1:0] held;
    int k;
    exp_t e;
    full = {1'b0, a} + {1'b0, b};
    e.sum = full[W-1:0];
    e.cy = full[W];
    e.addend = ser;
    sb.push_back(e);
    lastSum = e.sum;
    lastCy = e.cy;
    @(negedge clk);
    opA = a; opB = b; start = 1'b1; shiftEn = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(sum == a, "R2 augend loaded", sum, a);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(carryOut == 1'b0, "R3 carry cleared", carryOut, 0);
    k = 0;
    for (int c = 0; k < W; c++) begin
      bit go;
      go = !(stall && (c % 3 == 2));
      shiftEn = go;
      serIn = ser[k];
      if (inject && c == 1) begin
        start = 1'b1; opA = ~a; opB = ~b;
      end else begin
        start = 1'b0;
      end
      held = sum;
      @(negedge clk);
      if (!go) check(sum == held, "R5 stall holds sum", sum, held);
      if (inject && c == 1) check(busy == 1'b1, "R8 start ignored while busy", busy, 1);
      if (go) k++;
    end
    shiftEn = 1'b0;
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    clear = 1'b1; start = 1'b0; shiftEn = 1'b0; serIn = 1'b0;
    opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    check(sum == '0, "R1 sum cleared", sum, 0);
    check(addend == '0, "R1 addend cleared", addend, 0);
    check(carryOut == 1'b0, "R1 carry cleared", carryOut, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 idle flags", {busy, done}, 0);
    clear = 1'b0;

    runAdd(8'hFF, 8'h01, 8'hA5, 1'b0, 1'b0);   // R4 full carry ripple
    runAdd(8'h00, 8'h00, 8'h3C, 1'b0, 1'b0);   // R3 carry back to 0 after a carry run
    runAdd(8'h80, 8'h80, 8'h01, 1'b1, 1'b0);   // R5 with stalls
    runAdd(8'h5A, 8'h33, 8'hF0, 1'b0, 1'b1);   // R8 injected start
    repeat (4) @(negedge clk);
    check(sum == lastSum, "R9 sum held", sum, lastSum);
    check(carryOut == lastCy, "R9 carry held", carryOut, lastCy);
    for (int i = 0; i < 40; i++) begin
      runAdd(W'($urandom), W'($urandom), W'($urandom), bit'($urandom), bit'($urandom));
    end
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R6 every addition signalled done", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule